// File: doc/BRIEF.md
# Write-Invalidate Snooping Coherence Controller

This block keeps one small direct-mapped, one-word-per-line cache coherent with its peers on a shared snooping bus. Each line is invalid, shared (clean, possibly held elsewhere) or modified (the only copy, newer than memory). Processor reads and writes finish locally when the line state allows it. Otherwise the controller requests the bus and, once granted, performs one transaction: a fetch of the missing word, an invalidate that takes exclusive ownership before a write, or a write-back of a dirty victim. The processor request is then re-evaluated on the next cycle, so a write miss becomes fetch, then invalidate, then local write.

The same block watches the bus traffic of the other caches. When another cache announces an invalidate for a word this cache holds, the local copy is dropped. When another cache misses on a word this cache holds modified, the block drives the current value onto the bus in that cycle, and the surrounding bus logic also writes it to memory. The line then falls back to shared. The controller is purely reactive: it keeps no transaction state of its own besides the line array, and it re-evaluates what is needed in every cycle. Snoops and local grants are applied in a single bus order, so every cache sees writes to a word in the same sequence.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid: no acknowledge and no bus request without a processor request, and the first access to any address requests the bus.
- R2: A read that hits a shared or modified line is acknowledged in the same cycle with the stored word and raises no bus request.
- R3: A read miss on a clean or empty line requests the bus with command 1 (fetch) and the processor address; in the granted cycle the word on bus_rdata is loaded as shared, and the read is acknowledged one cycle later.
- R4: A write that hits a shared line requests the bus with command 2 (invalidate) and the processor address; after the grant the line is modified and the write then completes locally.
- R5: A write that hits a modified line is acknowledged in the same cycle with no bus request, and later reads return the new word.
- R6: A write miss costs exactly two bus transactions, a fetch and then an invalidate, before it is acknowledged.
- R7: A miss whose victim line is modified first requests command 3 (write-back) with the victim's address (stored tag above the index) and word; after that grant the victim is invalid and the fetch follows.
- R8: A snooped command 2 whose address matches a held line makes that line invalid, so the next local access to it goes to the bus.
- R9: A snooped command 1 whose address matches a modified line raises snp_supply with the stored word in the same cycle, and the line becomes shared, so a later local write needs an invalidate.
- R10: Snooped traffic that does not match a held line, a snooped fetch of a shared line, and a snooped write-back (command 3) change nothing.
- R11: The bus is requested only while a processor request is pending and cannot complete locally; the acknowledge and the bus request are never high together.
- R12: A local access that would hit is held off (no acknowledge) in any cycle in which a snoop addresses the same line index; it completes in the first cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access pending, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ack | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ack on a read |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Grant; the requested transaction happens in this cycle |
| bus_cmd | output | 2 | 1 fetch, 2 invalidate, 3 write-back, 0 none |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Word carried by a write-back |
| bus_rdata | input | DATA_W | Word returned for a granted fetch |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| snp_supply | output | 1 | This cache provides the data for the snooped fetch |
| snp_data | output | DATA_W | Supplied word |

## Verification
Directed sequences walk one word through every state change (clean miss, read hit, write from shared, write on modified, remote fetch of a dirty copy, remote invalidate) and count granted transactions per access, which separates a write miss (two transactions) from a dirty eviction (write-back then fetch) and from local hits (none). Snoops that miss on tag but share the index, and snoops colliding with a local hit in the same cycle, tell apart a real state change from a held-off acknowledge. A long seeded random phase mixes held requests, partial grants and snoops over three tags per index, so evictions, ownership loss in mid-request and back-to-back remote traffic all occur against a cycle-level reference model.

// File: rtl/coh_pkg.sv
package coh_pkg;

   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHR = 2'd1,
      LS_MOD = 2'd2
   } line_st_e;

   typedef enum logic [1:0] {
      BC_IDLE  = 2'd0,
      BC_FETCH = 2'd1,
      BC_INVAL = 2'd2,
      BC_WBACK = 2'd3
   } bus_cmd_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
   import coh_pkg::*;
#(
   parameter int LINES  = 4,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   // local port: granted transactions and processor writes
   input  logic              a_en,
   input  logic [IDX_W-1:0]  a_idx,
   input  line_st_e          a_st,
   input  logic              a_ld_tag,
   input  logic [TAG_W-1:0]  a_tag,
   input  logic              a_ld_dat,
   input  logic [DATA_W-1:0] a_dat,
   // snoop port: state changes only
   input  logic              b_en,
   input  logic [IDX_W-1:0]  b_idx,
   input  line_st_e          b_st,
   // read ports
   input  logic [IDX_W-1:0]  c_idx,
   output line_st_e          c_st,
   output logic [TAG_W-1:0]  c_tag,
   output logic [DATA_W-1:0] c_dat,
   input  logic [IDX_W-1:0]  s_idx,
   output line_st_e          s_st,
   output logic [TAG_W-1:0]  s_tag,
   output logic [DATA_W-1:0] s_dat
);

   line_st_e          st_arr  [LINES];
   logic [TAG_W-1:0]  tag_arr [LINES];
   logic [DATA_W-1:0] dat_arr [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_e          st_r;
      logic [TAG_W-1:0]  tag_r;
      logic [DATA_W-1:0] dat_r;
      logic              sel_a;
      logic              sel_b;

      assign sel_a = a_en && (a_idx == IDX_W'(g));
      assign sel_b = b_en && (b_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_r  <= LS_INV;
            tag_r <= '0;
            dat_r <= '0;
         end else if (sel_a) begin
            st_r <= a_st;
            if (a_ld_tag) tag_r <= a_tag;
            if (a_ld_dat) dat_r <= a_dat;
         end else if (sel_b) begin
            st_r <= b_st;
         end
      end

      assign st_arr[g]  = st_r;
      assign tag_arr[g] = tag_r;
      assign dat_arr[g] = dat_r;
   end

   assign c_st  = st_arr[c_idx];
   assign c_tag = tag_arr[c_idx];
   assign c_dat = dat_arr[c_idx];
   assign s_st  = st_arr[s_idx];
   assign s_tag = tag_arr[s_idx];
   assign s_dat = dat_arr[s_idx];

endmodule

// File: rtl/coh_req_decode.sv
module coh_req_decode
   import coh_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  logic             cpu_req,
   input  logic             cpu_we,
   input  logic [TAG_W-1:0] cpu_tag,
   input  line_st_e         ln_st,
   input  logic [TAG_W-1:0] ln_tag,
   input  logic             snp_clash,
   output bus_cmd_e         need,
   output logic             hit,
   output logic             done
);

   always_comb begin
      hit  = (ln_st != LS_INV) && (ln_tag == cpu_tag);
      need = BC_IDLE;
      if (cpu_req) begin
         if (!hit)
            need = (ln_st == LS_MOD) ? BC_WBACK : BC_FETCH;
         else if (cpu_we && ln_st == LS_SHR)
            need = BC_INVAL;
      end
      done = cpu_req && hit && (need == BC_IDLE) && !snp_clash;
   end

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
   import coh_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  logic             snp_valid,
   input  logic [1:0]       snp_cmd,
   input  logic [TAG_W-1:0] snp_tag,
   input  line_st_e         ln_st,
   input  logic [TAG_W-1:0] ln_tag,
   input  logic             own_busy,
   output logic             supply,
   output logic             upd_en,
   output line_st_e         upd_st
);

   logic match;

   always_comb begin
      match  = snp_valid && (ln_st != LS_INV) && (ln_tag == snp_tag);
      supply = match && (snp_cmd == BC_FETCH) && (ln_st == LS_MOD);
      upd_en = 1'b0;
      upd_st = ln_st;
      if (match && !own_busy) begin
         if (snp_cmd == BC_INVAL) begin
            upd_en = 1'b1;
            upd_st = LS_INV;
         end else if (supply) begin
            upd_en = 1'b1;
            upd_st = LS_SHR;
         end
      end
   end

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
   import coh_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int LINES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ack,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_supply,
   output logic [DATA_W-1:0] snp_data
);

   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two and at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [IDX_W-1:0]  c_idx, s_idx;
   logic [TAG_W-1:0]  c_tagin, s_tagin;
   line_st_e          c_st, s_st;
   logic [TAG_W-1:0]  c_tag, s_tag;
   logic [DATA_W-1:0] c_dat, s_dat;
   bus_cmd_e          need;
   logic              hit, done, clash, granted;
   logic              a_en, a_ld_tag, a_ld_dat;
   line_st_e          a_st;
   logic [DATA_W-1:0] a_dat;
   logic              b_en;
   line_st_e          b_st;

   assign c_idx   = cpu_addr[IDX_W-1:0];
   assign c_tagin = cpu_addr[ADDR_W-1:IDX_W];
   assign s_idx   = snp_addr[IDX_W-1:0];
   assign s_tagin = snp_addr[ADDR_W-1:IDX_W];
   assign clash   = snp_valid && (s_idx == c_idx);

   coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .a_en(a_en), .a_idx(c_idx), .a_st(a_st), .a_ld_tag(a_ld_tag),
      .a_tag(c_tagin), .a_ld_dat(a_ld_dat), .a_dat(a_dat),
      .b_en(b_en), .b_idx(s_idx), .b_st(b_st),
      .c_idx(c_idx), .c_st(c_st), .c_tag(c_tag), .c_dat(c_dat),
      .s_idx(s_idx), .s_st(s_st), .s_tag(s_tag), .s_dat(s_dat)
   );

   coh_req_decode #(.TAG_W(TAG_W)) u_dec (
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(c_tagin),
      .ln_st(c_st), .ln_tag(c_tag), .snp_clash(clash),
      .need(need), .hit(hit), .done(done)
   );

   assign bus_req = (need != BC_IDLE);
   assign granted = bus_req && bus_gnt;

   coh_snoop_unit #(.TAG_W(TAG_W)) u_snp (
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(s_tagin),
      .ln_st(s_st), .ln_tag(s_tag), .own_busy(granted),
      .supply(snp_supply), .upd_en(b_en), .upd_st(b_st)
   );

   always_comb begin
      a_en     = 1'b0;
      a_st     = c_st;
      a_ld_tag = 1'b0;
      a_ld_dat = 1'b0;
      a_dat    = cpu_wdata;
      if (granted) begin
         a_en = 1'b1;
         unique case (need)
            BC_FETCH: begin
               a_st     = LS_SHR;
               a_ld_tag = 1'b1;
               a_ld_dat = 1'b1;
               a_dat    = bus_rdata;
            end
            BC_INVAL: a_st = LS_MOD;
            BC_WBACK: a_st = LS_INV;
            default:  a_en = 1'b0;
         endcase
      end else if (done && cpu_we) begin
         a_en     = 1'b1;
         a_st     = LS_MOD;
         a_ld_dat = 1'b1;
      end
   end

   assign cpu_ack   = done;
   assign cpu_rdata = c_dat;
   assign bus_cmd   = need;
   assign bus_addr  = (need == BC_WBACK) ? {c_tag, c_idx} : cpu_addr;
   assign bus_wdata = c_dat;
   assign snp_data  = s_dat;

   logic unused_hit;
   assign unused_hit = hit;

endmodule

// File: rtl/coh_snoop_chk.sv
module coh_snoop_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_ack,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic [1:0]        bus_cmd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              snp_valid,
   input logic [1:0]        snp_cmd,
   input logic [ADDR_W-1:0] snp_addr,
   input logic              snp_supply,
   input logic [DATA_W-1:0] snp_data
);

   p_req_needs_cpu_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> cpu_req);

   p_ack_no_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> (cpu_req && !bus_req));

   p_inval_only_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_cmd == 2'd2) |-> cpu_we);

   p_supply_on_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> (snp_valid && snp_cmd == 2'd1));

   p_supply_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |=> !(snp_supply && snp_addr == $past(snp_addr)));

   p_wback_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_cmd == 2'd3)
      |=> !(bus_req && bus_cmd == 2'd3 && bus_addr == $past(bus_addr)));

   p_hit_after_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && !snp_valid && $past(cpu_req && !cpu_we)
       && $past(bus_req && bus_gnt && bus_cmd == 2'd1)
       && cpu_addr == $past(cpu_addr)) |-> cpu_ack);

   logic unused_d;
   assign unused_d = ^snp_data;

endmodule

bind coh_snoop_ctrl coh_snoop_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
   .cpu_addr(cpu_addr), .cpu_ack(cpu_ack), .bus_req(bus_req),
   .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
   .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
   .snp_supply(snp_supply), .snp_data(snp_data)
);

// File: tb/coh_snoop_ctrl_tb.sv
module coh_snoop_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [7:0]  cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_ack;
   logic [15:0] cpu_rdata;
   logic        bus_req;
   logic        bus_gnt = 1'b0;
   logic [1:0]  bus_cmd;
   logic [7:0]  bus_addr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata = '0;
   logic        snp_valid = 1'b0;
   logic [1:0]  snp_cmd = '0;
   logic [7:0]  snp_addr = '0;
   logic        snp_supply;
   logic [15:0] snp_data;

   always #10 clk = ~clk;

   coh_snoop_ctrl #(.ADDR_W(8), .DATA_W(16), .LINES(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
      .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
      .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
      .snp_addr(snp_addr), .snp_supply(snp_supply), .snp_data(snp_data)
   );

   int checks = 0;
   int fails  = 0;

   // reference model: 0 invalid, 1 shared, 2 modified
   int          m_st  [4];
   logic [5:0]  m_tag [4];
   logic [15:0] m_dat [4];
   logic [15:0] mem   [256];
   bit          last_ack, last_gnt;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] f_need(input bit req, input bit we,
                                         input logic [7:0] a);
      int i = int'(a[1:0]);
      bit h = (m_st[i] != 0) && (m_tag[i] == a[7:2]);
      if (!req) return 2'd0;
      if (!h) return (m_st[i] == 2) ? 2'd3 : 2'd1;
      if (we && m_st[i] == 1) return 2'd2;
      return 2'd0;
   endfunction

   // one cycle, entered at a falling edge, left at the next falling edge
   task automatic cyc(input bit req, input bit we, input logic [7:0] a,
                      input logic [15:0] wd, input bit gmode, input bit sv,
                      input logic [1:0] sc, input logic [7:0] sa);
      logic [1:0] nd;
      logic [7:0] ea;
      int i, si;
      bit h, g, clash, eack, shit, esup;
      cpu_req = req; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      snp_valid = sv; snp_cmd = sc; snp_addr = sa; bus_gnt = 1'b0;
      #1;
      i  = int'(a[1:0]);
      nd = f_need(req, we, a);
      g  = gmode && (nd != 2'd0);
      if (g) begin sv = 1'b0; snp_valid = 1'b0; end
      ea = (nd == 2'd3) ? {m_tag[i], a[1:0]} : a;
      bus_gnt = g;
      bus_rdata = mem[ea];
      #1;
      h     = (m_st[i] != 0) && (m_tag[i] == a[7:2]);
      clash = sv && (sa[1:0] == a[1:0]);
      eack  = req && (nd == 2'd0) && h && !clash;
      chk(bus_req == (nd != 2'd0), "R11 bus_req", 32'(bus_req), 32'(nd != 2'd0));
      if (nd != 2'd0) begin
         chk(bus_cmd == nd, (nd == 2'd1) ? "R3 cmd" : (nd == 2'd2) ? "R4 cmd" : "R7 cmd",
             32'(bus_cmd), 32'(nd));
         chk(bus_addr == ea, "R7 bus_addr", 32'(bus_addr), 32'(ea));
         if (nd == 2'd3)
            chk(bus_wdata == m_dat[i], "R7 wdata", 32'(bus_wdata), 32'(m_dat[i]));
      end
      chk(cpu_ack == eack, clash ? "R12 ack" : (we ? "R5 ack" : "R2 ack"),
          32'(cpu_ack), 32'(eack));
      if (eack && !we)
         chk(cpu_rdata == m_dat[i], "R2 rdata", 32'(cpu_rdata), 32'(m_dat[i]));
      si   = int'(sa[1:0]);
      shit = sv && (m_st[si] != 0) && (m_tag[si] == sa[7:2]);
      esup = shit && (sc == 2'd1) && (m_st[si] == 2);
      chk(snp_supply == esup, "R9 supply", 32'(snp_supply), 32'(esup));
      if (esup)
         chk(snp_data == m_dat[si], "R9 snp_data", 32'(snp_data), 32'(m_dat[si]));
      @(posedge clk);
      if (g) begin
         case (nd)
            2'd1: begin m_st[i] = 1; m_tag[i] = a[7:2]; m_dat[i] = mem[a]; end
            2'd2: m_st[i] = 2;
            default: begin mem[ea] = bus_wdata; m_st[i] = 0; end
         endcase
      end else if (shit) begin
         if (sc == 2'd2) m_st[si] = 0;
         else if (esup) begin mem[sa] = snp_data; m_st[si] = 1; end
      end
      if (eack && we) begin m_dat[i] = wd; m_st[i] = 2; end
      last_ack = eack;
      last_gnt = g;
      @(negedge clk);
   endtask

   task automatic access(input bit we, input logic [7:0] a, input logic [15:0] wd,
                         output int ntr);
      ntr = 0;
      for (int k = 0; k < 10; k++) begin
         cyc(1'b1, we, a, wd, 1'b1, 1'b0, 2'd0, 8'd0);
         if (last_gnt) ntr++;
         if (last_ack) break;
      end
   endtask

   task automatic snoop(input logic [1:0] sc, input logic [7:0] sa);
      cyc(1'b0, 1'b0, 8'd0, 16'd0, 1'b0, 1'b1, sc, sa);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      int n;
      bit pend;
      logic [7:0]  ra, sa;
      logic [15:0] rw;
      bit rwe;
      void'($urandom(32'd1234));
      for (int k = 0; k < 4; k++) begin m_st[k] = 0; m_tag[k] = '0; m_dat[k] = '0; end
      for (int k = 0; k < 256; k++) mem[k] = 16'(k * 3 + 1);
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: idle after reset, then everything misses
      #2;
      chk(!cpu_ack && !bus_req, "R1 idle after reset", {cpu_ack, bus_req}, 0);
      @(negedge clk);
      access(1'b0, 8'h05, 16'h0, n);
      chk(n == 1, "R1 R3 first read fetches once", n, 1);
      access(1'b0, 8'h05, 16'h0, n);
      chk(n == 0, "R2 read hit no bus", n, 0);
      access(1'b1, 8'h05, 16'hAAAA, n);
      chk(n == 1, "R4 write hit shared invalidates", n, 1);
      access(1'b1, 8'h05, 16'hBBBB, n);
      chk(n == 0, "R5 write hit modified", n, 0);
      access(1'b0, 8'h05, 16'h0, n);
      chk(n == 0, "R5 read back after write", n, 0);
      snoop(2'd1, 8'h05);
      chk(mem[8'h05] == 16'hBBBB, "R9 memory updated by supply", mem[8'h05], 16'hBBBB);
      access(1'b1, 8'h05, 16'hCCCC, n);
      chk(n == 1, "R9 line dropped to shared", n, 1);
      snoop(2'd1, 8'h09);
      snoop(2'd3, 8'h05);
      access(1'b0, 8'h05, 16'h0, n);
      chk(n == 0, "R10 unrelated snoops keep line", n, 0);
      access(1'b1, 8'h0A, 16'h1234, n);
      chk(n == 2, "R6 write miss two transactions", n, 2);
      access(1'b0, 8'h0E, 16'h0, n);
      chk(n == 2, "R7 dirty victim written back first", n, 2);
      chk(mem[8'h0A] == 16'h1234, "R7 written back word", mem[8'h0A], 16'h1234);
      snoop(2'd2, 8'h02);
      access(1'b0, 8'h0E, 16'h0, n);
      chk(n == 0, "R10 invalidate of other tag ignored", n, 0);
      snoop(2'd2, 8'h0E);
      access(1'b0, 8'h0E, 16'h0, n);
      chk(n == 1, "R8 invalidated line misses", n, 1);
      cyc(1'b1, 1'b0, 8'h0E, 16'h0, 1'b1, 1'b1, 2'd1, 8'h02);
      chk(!last_ack, "R12 held off by same index snoop", last_ack, 0);
      cyc(1'b1, 1'b0, 8'h0E, 16'h0, 1'b1, 1'b0, 2'd0, 8'h00);
      chk(last_ack, "R12 completes after snoop", last_ack, 1);

      // seeded random phase
      pend = 1'b0; ra = '0; rw = '0; rwe = 1'b0;
      for (int t = 0; t < 4000; t++) begin
         bit sv;
         if (!pend && ($urandom % 100) < 85) begin
            pend = 1'b1;
            rwe  = ($urandom % 2) == 1;
            ra   = {6'($urandom % 3), 2'($urandom % 4)};
            rw   = 16'($urandom);
         end
         sv = ($urandom % 100) < 25;
         sa = {6'($urandom % 3), 2'($urandom % 4)};
         cyc(pend, rwe, ra, rw, ($urandom % 100) < 70, sv,
             2'(1 + ($urandom % 3)), sa);
         if (last_ack) pend = 1'b0;
      end
      finish_run();
   end

endmodule